// File: doc/BRIEF.md
# SD Card Command Path Engine

This block drives the command half of an SD card host. Software loads a 32-bit argument and a response timeout start value, then writes a 16-bit command word with its top bit set. The engine serialises the 48-bit command frame on the CMD line, one bit per card-clock strobe. It then waits a bounded number of strobes for the card's start bit, shifts in a 48-bit or 136-bit response, checks its CRC7 and places the response in four 32-bit response outputs. For commands that leave the card busy, it also waits for DAT0 to be released.

Completion is reported by the top bit of the command word falling back to zero. A failed command leaves a sticky fail bit in the command word and a cause bit in the host status word. Per-command flags select no response, a long response or a busy wait. Clock generation, the data lines and the FIFO sit outside this block: the card-clock strobe is an input pulse one system clock wide.

Top module: `sdc_cmd_engine`

## Requirements
- R1: After reset, the command word, host status and all four response outputs read 0, the CMD line output is 1 and its output enable is 0.
- R2: Writing byte offset 0x00 with bit 15 set while idle launches a 48-bit frame. The frame is sent MSB first: a 0, a 1, the index from bits [5:0], the argument from offset 0x04, a CRC7 over those first 40 bits (polynomial x^7+x^3+1, zero seed) and a final 1. One bit is sent per strobe, and the output enable is high for exactly those 48 strobes. When the enable is low, the CMD line output is 1.
- R3: Bit 15 of the command word reads 1 from the launch until the command ends, then 0. A command with bit 10 (no response) set ends at the strobe that sends its last frame bit.
- R4: A short response is 48 bits long, starting with a 0 bit. The 32 bits received at positions 8 to 39 (position 0 is the start bit) go MSB first into response word 0. Response words 1 to 3 keep their values.
- R5: With bit 9 (long) set, the response is 136 bits. The bits at positions 8 to 135 fill response words 3 down to 0, and the bit at position 8 lands in bit 31 of word 3. The CRC7 covers positions 8 to 127 only.
- R6: A mismatch between the received CRC7 and the computed one ends the command with bit 14 (fail) of the command word set and bit 4 of the host status set.
- R7: Offset 0x08 holds the timeout start value T. A start bit is accepted only within the first T+1 strobes after the frame. If none arrives, the command fails with bit 14 set and host status bit 6 set, and the response outputs are left unchanged.
- R8: With bit 11 (busy wait) set, bit 15 stays 1 after the response until DAT0 is sampled high on a strobe. At that point host status bit 10 is set and bit 15 clears. If DAT0 stays low for T+1 strobes after the response, the command fails with host status bit 6.
- R9: A launch that sets both bit 9 and bit 11 is rejected. From the next cycle, bit 15 reads 0 and bit 14 reads 1, and no frame is driven.
- R10: A write to the command word while bit 15 reads 1 is ignored, and the frame in flight continues unchanged.
- R11: The host status bits are sticky. Writing offset 0x20 clears each status bit whose written data bit is 1, and a status event in the same cycle wins over the clear. Any accepted command word write clears the fail bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Card-clock strobe, one cycle wide |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| cmd_word_o | output | 16 | Command word including the new and fail flags |
| host_stat_o | output | 11 | Host status: bit 10 busy done, bit 6 timeout, bit 4 CRC7 error |
| resp0_o | output | 32 | Response bits 31:0 |
| resp1_o | output | 32 | Response bits 63:32 |
| resp2_o | output | 32 | Response bits 95:64 |
| resp3_o | output | 32 | Response bits 127:96 |
| cmd_line_o | output | 1 | CMD line drive value |
| cmd_line_oe_o | output | 1 | CMD line output enable |
| cmd_line_i | input | 1 | CMD line sampled value |
| dat0_i | input | 1 | DAT0 line sampled value |

## Verification
The bound assertions check on every cycle the properties that hold at the ports. The CMD line is driven only while a command is in flight and idles high. A failure always comes with a cause bit. The busy-done bit rises only at the cycle the command ends. The response outputs change only while a command is active. The command index cannot change under an active command, and a long-plus-busy launch is rejected at once. Only the bench scenarios can show that the frame bits and CRC7 are correct, that the received bits land in the right response positions, and where the timeout boundary falls (T and T+1 strobes of gap). They also show that a corrupted CRC, a DAT0 hold and a status clear each give the expected result.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int WORD_W  = 32;
    localparam int CMDW_W  = 16;
    localparam int STAT_W  = 11;
    localparam int CRC_W   = 7;
    localparam int HDR_W   = 40;
    localparam int CNT_W   = 8;

    // command word bit positions
    localparam int CB_NEW   = 15;
    localparam int CB_FAIL  = 14;
    localparam int CB_BUSY  = 11;
    localparam int CB_NORSP = 10;
    localparam int CB_LONG  = 9;

    // host status bit positions
    localparam int SB_BUSYDONE = 10;
    localparam int SB_TMO      = 6;
    localparam int SB_CRC      = 4;

    // register byte offsets
    localparam int OFS_CMD  = 'h00;
    localparam int OFS_ARG  = 'h04;
    localparam int OFS_TMO  = 'h08;
    localparam int OFS_STAT = 'h20;

    // bit positions within frames and responses
    localparam logic [CNT_W-1:0] POS_HDR_END   = 8'd40;
    localparam logic [CNT_W-1:0] POS_SHORT_END = 8'd47;
    localparam logic [CNT_W-1:0] POS_PAY_START = 8'd8;
    localparam logic [CNT_W-1:0] POS_LONG_CRC  = 8'd128;
    localparam logic [CNT_W-1:0] POS_LONG_END  = 8'd135;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX,
        ST_WAIT,
        ST_RX,
        ST_BUSY
    } eng_state_e;
endpackage

// File: rtl/sdc_crc7_step.sv
module sdc_crc7_step #(
    parameter int               W    = 7,
    parameter logic [W-1:0]     POLY = 7'h09
) (
    input  logic [W-1:0] crc_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = crc_i[W-1] ^ bit_i;
        crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/sdc_wait_timer.sv
module sdc_wait_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         tick_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
    import sdc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int TMO_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [15:0]       cmd_word_o,
    output logic [10:0]       host_stat_o,
    output logic [31:0]       resp0_o,
    output logic [31:0]       resp1_o,
    output logic [31:0]       resp2_o,
    output logic [31:0]       resp3_o,
    output logic              cmd_line_o,
    output logic              cmd_line_oe_o,
    input  logic              cmd_line_i,
    input  logic              dat0_i
);
    localparam int RESP_W = 4 * WORD_W;

    typedef struct packed {
        eng_state_e          st;
        logic [CMDW_W-1:0]   cmd;
        logic [WORD_W-1:0]   arg;
        logic [TMO_W-1:0]    tmo;
        logic [STAT_W-1:0]   stat;
        logic [RESP_W-1:0]   resp;
        logic [RESP_W-1:0]   rxsh;
        logic [HDR_W-1:0]    txsh;
        logic [CRC_W-1:0]    crc;
        logic [CNT_W-1:0]    cnt;
        logic                crc_bad;
    } eng_regs_t;

    eng_regs_t q, d;

    logic             crc_bit;
    logic [CRC_W-1:0] crc_nx;
    logic             tmr_load, tmr_tick, tmr_zero;
    logic             is_long, in_pay, in_chk, at_last;

    sdc_crc7_step #(.W(CRC_W), .POLY(7'h09)) u_crc (
        .crc_i (q.crc),
        .bit_i (crc_bit),
        .crc_o (crc_nx)
    );

    sdc_wait_timer #(.W(TMO_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (q.tmo),
        .tick_i (tmr_tick),
        .zero_o (tmr_zero)
    );

    always_comb begin
        d        = q;
        crc_bit  = 1'b0;
        tmr_load = 1'b0;
        tmr_tick = 1'b0;
        is_long  = q.cmd[CB_LONG];
        in_pay   = is_long ? (q.cnt >= POS_PAY_START && q.cnt < POS_LONG_CRC)
                           : (q.cnt < POS_HDR_END);
        in_chk   = is_long ? (q.cnt >= POS_LONG_CRC && q.cnt < POS_LONG_END)
                           : (q.cnt >= POS_HDR_END && q.cnt < POS_SHORT_END);
        at_last  = is_long ? (q.cnt == POS_LONG_END) : (q.cnt == POS_SHORT_END);

        // register writes
        if (reg_we_i) begin
            if (reg_addr_i == ADDR_W'(OFS_ARG)) begin
                d.arg = reg_wdata_i;
            end else if (reg_addr_i == ADDR_W'(OFS_TMO)) begin
                d.tmo = TMO_W'(reg_wdata_i);
            end else if (reg_addr_i == ADDR_W'(OFS_STAT)) begin
                d.stat = q.stat & ~reg_wdata_i[STAT_W-1:0];
            end else if (reg_addr_i == ADDR_W'(OFS_CMD) && !q.cmd[CB_NEW]) begin
                if (reg_wdata_i[CB_NEW] && reg_wdata_i[CB_LONG] && reg_wdata_i[CB_BUSY]) begin
                    d.cmd = {2'b01, reg_wdata_i[13:0]};
                end else begin
                    d.cmd = {reg_wdata_i[CB_NEW], 1'b0, reg_wdata_i[13:0]};
                    if (reg_wdata_i[CB_NEW]) begin
                        d.st   = ST_TX;
                        d.txsh = {2'b01, reg_wdata_i[5:0], q.arg};
                        d.cnt  = '0;
                        d.crc  = '0;
                    end
                end
            end
        end

        // serial engine, advances on strobes only
        if (strobe_i) begin
            case (q.st)
                ST_TX: begin
                    if (q.cnt < POS_HDR_END) begin
                        crc_bit = q.txsh[HDR_W-1];
                        d.crc   = crc_nx;
                        d.txsh  = {q.txsh[HDR_W-2:0], 1'b0};
                    end else if (q.cnt < POS_SHORT_END) begin
                        d.crc = {q.crc[CRC_W-2:0], 1'b0};
                    end
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == POS_SHORT_END) begin
                        if (q.cmd[CB_NORSP]) begin
                            d.st          = ST_IDLE;
                            d.cmd[CB_NEW] = 1'b0;
                        end else begin
                            d.st     = ST_WAIT;
                            tmr_load = 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!cmd_line_i) begin
                        d.st      = ST_RX;
                        d.cnt     = 8'd1;
                        d.crc     = '0;
                        d.crc_bad = 1'b0;
                    end else if (tmr_zero) begin
                        d.st           = ST_IDLE;
                        d.cmd[CB_NEW]  = 1'b0;
                        d.cmd[CB_FAIL] = 1'b1;
                        d.stat[SB_TMO] = 1'b1;
                    end else begin
                        tmr_tick = 1'b1;
                    end
                end
                ST_RX: begin
                    if (in_pay) begin
                        crc_bit = cmd_line_i;
                        d.crc   = crc_nx;
                    end
                    if (in_chk) begin
                        if (cmd_line_i != q.crc[CRC_W-1]) d.crc_bad = 1'b1;
                        d.crc = {q.crc[CRC_W-2:0], 1'b0};
                    end
                    if (is_long && q.cnt >= POS_PAY_START) begin
                        d.rxsh = {q.rxsh[RESP_W-2:0], cmd_line_i};
                    end else if (!is_long && in_pay && q.cnt >= POS_PAY_START) begin
                        d.rxsh[WORD_W-1:0] = {q.rxsh[WORD_W-2:0], cmd_line_i};
                    end
                    d.cnt = q.cnt + 1'b1;
                    if (at_last) begin
                        if (is_long) d.resp = d.rxsh;
                        else         d.resp[WORD_W-1:0] = q.rxsh[WORD_W-1:0];
                        if (d.crc_bad) begin
                            d.st           = ST_IDLE;
                            d.cmd[CB_NEW]  = 1'b0;
                            d.cmd[CB_FAIL] = 1'b1;
                            d.stat[SB_CRC] = 1'b1;
                        end else if (q.cmd[CB_BUSY]) begin
                            d.st     = ST_BUSY;
                            tmr_load = 1'b1;
                        end else begin
                            d.st          = ST_IDLE;
                            d.cmd[CB_NEW] = 1'b0;
                        end
                    end
                end
                ST_BUSY: begin
                    if (dat0_i) begin
                        d.st                = ST_IDLE;
                        d.cmd[CB_NEW]       = 1'b0;
                        d.stat[SB_BUSYDONE] = 1'b1;
                    end else if (tmr_zero) begin
                        d.st           = ST_IDLE;
                        d.cmd[CB_NEW]  = 1'b0;
                        d.cmd[CB_FAIL] = 1'b1;
                        d.stat[SB_TMO] = 1'b1;
                    end else begin
                        tmr_tick = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        cmd_line_oe_o = (q.st == ST_TX);
        cmd_line_o    = 1'b1;
        if (q.st == ST_TX) begin
            if (q.cnt < POS_HDR_END)        cmd_line_o = q.txsh[HDR_W-1];
            else if (q.cnt < POS_SHORT_END) cmd_line_o = q.crc[CRC_W-1];
        end
    end

    assign cmd_word_o  = q.cmd;
    assign host_stat_o = q.stat;
    assign resp0_o     = q.resp[WORD_W-1:0];
    assign resp1_o     = q.resp[2*WORD_W-1:WORD_W];
    assign resp2_o     = q.resp[3*WORD_W-1:2*WORD_W];
    assign resp3_o     = q.resp[4*WORD_W-1:3*WORD_W];
endmodule

// File: rtl/sdc_cmd_engine_chk.sv
module sdc_cmd_engine_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic [15:0]       cmd_word_o,
    input logic [10:0]       host_stat_o,
    input logic [31:0]       resp0_o,
    input logic [31:0]       resp1_o,
    input logic [31:0]       resp2_o,
    input logic [31:0]       resp3_o,
    input logic              cmd_line_o,
    input logic              cmd_line_oe_o
);
    localparam logic [31:0] REJECT_MASK = 32'h0000_8A00;
    localparam logic [10:0] CAUSE_MASK  = 11'h050;

    // R2
    oe_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_line_oe_o |-> cmd_word_o[15]);

    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_line_oe_o |-> cmd_line_o);

    // R6
    fail_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cmd_word_o[15]) && cmd_word_o[14]) |-> ((host_stat_o & CAUSE_MASK) != '0));

    // R8
    busy_done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_stat_o[10]) |-> $fell(cmd_word_o[15]));

    // R4
    resp_only_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({resp3_o, resp2_o, resp1_o, resp0_o}) |-> $past(cmd_word_o[15]));

    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_word_o[15]) |-> $stable(cmd_word_o[13:0]));

    // R9
    long_busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we_i) && ($past(reg_addr_i) == ADDR_W'(0)) &&
         (($past(reg_wdata_i) & REJECT_MASK) == REJECT_MASK) && !$past(cmd_word_o[15]))
        |-> (!cmd_word_o[15] && cmd_word_o[14]));
endmodule

bind sdc_cmd_engine sdc_cmd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sdc_cmd_engine_test.sv
module sdc_cmd_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        line_in = 1'b1;
    logic        dat0 = 1'b1;
    logic [15:0] cmd_word;
    logic [10:0] stat;
    logic [31:0] r0, r1, r2, r3;
    logic        line_out, line_oe;

    int errors = 0;
    int checks = 0;
    int oe_seen = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdc_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .cmd_word_o(cmd_word),
        .host_stat_o(stat), .resp0_o(r0), .resp1_o(r1), .resp2_o(r2),
        .resp3_o(r3), .cmd_line_o(line_out), .cmd_line_oe_o(line_oe),
        .cmd_line_i(line_in), .dat0_i(dat0)
    );

    typedef struct packed {
        logic [15:0] cmd;
        logic [31:0] arg;
        logic [7:0]  gap;
        logic        bad;
        logic        exp_fail;
        logic        exp_tmo;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'h8400, 32'h0000_0000, 8'd0, 1'b0, 1'b0, 1'b0},
        '{16'h8011, 32'h0000_0200, 8'd2, 1'b0, 1'b0, 1'b0},
        '{16'h8008, 32'h0000_01AA, 8'd8, 1'b0, 1'b0, 1'b0},
        '{16'h8202, 32'h0000_0000, 8'd0, 1'b0, 1'b0, 1'b0},
        '{16'h800D, 32'h1234_0000, 8'd9, 1'b0, 1'b1, 1'b1},
        '{16'h8037, 32'hDEAD_BEEF, 8'd1, 1'b1, 1'b1, 1'b0},
        '{16'h8209, 32'h0F0F_3C3C, 8'd3, 1'b1, 1'b1, 1'b0}
    };

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7(input logic [127:0] data, input int n);
        logic [6:0] c = '0;
        logic fb;
        for (int i = n - 1; i >= 0; i--) begin
            fb = c[6] ^ data[i];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] h = {2'b01, idx, arg};
        return {h, crc7({88'b0, h}, 40), 1'b1};
    endfunction

    function automatic logic [135:0] short_resp(input logic [5:0] idx, input logic [31:0] p,
                                                input logic bad);
        logic [39:0] h = {2'b00, idx, p};
        logic [6:0]  c = crc7({88'b0, h}, 40) ^ {6'b0, bad};
        return {h, c, 1'b1, 88'b0};
    endfunction

    function automatic logic [135:0] long_resp(input logic [119:0] p, input logic bad);
        logic [6:0] c = crc7({8'b0, p}, 120) ^ {6'b0, bad};
        return {2'b00, 6'h3F, p, c, 1'b1};
    endfunction

    function automatic logic [127:0] resp_all();
        return {r3, r2, r1, r0};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] dv);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = dv;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic step(input logic ln, input logic d0, output logic o);
        @(negedge clk);
        line_in = ln; dat0 = d0; strobe = 1'b1;
        o = line_out;
        if (line_oe) oe_seen++;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic send_frame(input logic [15:0] c, input logic [31:0] a, input logic [31:0] t,
                              output logic [47:0] fr);
        logic o;
        oe_seen = 0;
        wr(8'h04, a);
        wr(8'h08, t);
        wr(8'h00, {16'h0, c});
        fr = '0;
        for (int i = 0; i < 48; i++) begin
            step(1'b1, 1'b1, o);
            fr = {fr[46:0], o};
        end
    endtask

    task automatic send_idle(input int n, input logic d0);
        logic o;
        for (int i = 0; i < n; i++) step(1'b1, d0, o);
    endtask

    task automatic send_bits(input logic [135:0] b, input int n);
        logic o;
        for (int i = 0; i < n; i++) step(b[135-i], 1'b1, o);
    endtask

    task automatic run_vec(input vec_t v);
        logic [47:0]  fr;
        logic [127:0] prev, exp_r;
        logic [31:0]  ps = v.arg ^ 32'hA5A5_0F0F;
        logic [119:0] pl = {v.arg, ~v.arg, v.arg ^ 32'h1357_9BDF, 24'hC0FFEE};
        logic [135:0] lr = long_resp(pl, v.bad);
        logic         nr = v.cmd[10];
        logic         lg = v.cmd[9];
        wr(8'h20, 32'h7FF);
        prev = resp_all();
        send_frame(v.cmd, v.arg, 32'd8, fr);
        check(fr == exp_frame(v.cmd[5:0], v.arg), "R2 frame bits", {80'b0, fr},
              {80'b0, exp_frame(v.cmd[5:0], v.arg)});
        if (!nr) begin
            send_idle(v.gap, 1'b1);
            if (lg) send_bits(lr, 136);
            else    send_bits(short_resp(v.cmd[5:0], ps, v.bad), 48);
        end
        send_idle(1, 1'b1);
        check(oe_seen == 48, "R2 enable strobes", 128'(oe_seen), 128'd48);
        check(cmd_word[15] == 1'b0, "R3 new flag cleared", {127'b0, cmd_word[15]}, 128'b0);
        check(cmd_word[14] == v.exp_fail, "R6 R7 fail flag", {127'b0, cmd_word[14]},
              {127'b0, v.exp_fail});
        check(stat[6] == v.exp_tmo, "R7 timeout status", {127'b0, stat[6]}, {127'b0, v.exp_tmo});
        check(stat[4] == (v.exp_fail && !v.exp_tmo), "R6 crc status", {127'b0, stat[4]},
              {127'b0, v.exp_fail && !v.exp_tmo});
        if (nr || v.exp_tmo) exp_r = prev;
        else if (lg)         exp_r = lr[127:0];
        else                 exp_r = {prev[127:32], ps};
        check(resp_all() == exp_r, lg ? "R5 long response" : "R4 short response",
              resp_all(), exp_r);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
            report();
            $finish;
        end
    end

    initial begin
        logic [47:0] fr;
        logic        o;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(cmd_word == 16'h0 && stat == 11'h0, "R1 reset words",
              {101'b0, cmd_word, stat}, 128'b0);
        check(resp_all() == '0, "R1 reset responses", resp_all(), 128'b0);
        check(line_out && !line_oe, "R1 reset line", {126'b0, line_out, line_oe}, 128'h2);

        // table of vectors: R2 R3 R4 R5 R6 R7
        foreach (VECS[i]) run_vec(VECS[i]);

        // R11 sticky status, then write-one-to-clear
        check(stat[4] == 1'b1, "R11 crc status held", {127'b0, stat[4]}, 128'b1);
        run_vec('{16'h8003, 32'h0000_5555, 8'd0, 1'b0, 1'b0, 1'b0});
        wr(8'h20, 32'h0);
        send_frame(16'h8403, 32'h1, 32'd4, fr);
        send_idle(1, 1'b1);
        wr(8'h20, 32'h010);
        check(stat == 11'h0, "R11 status cleared", {117'b0, stat}, 128'b0);

        // R7 timeout of zero accepts a start bit on the first strobe
        wr(8'h20, 32'h7FF);
        send_frame(16'h8021, 32'h0000_0077, 32'd0, fr);
        send_bits(short_resp(6'd33, 32'hCAFE_F00D, 1'b0), 48);
        send_idle(1, 1'b1);
        check(r0 == 32'hCAFE_F00D && !cmd_word[14], "R7 zero timeout start", {96'b0, r0},
              {96'b0, 32'hCAFE_F00D});

        // R10 write while active is ignored
        oe_seen = 0;
        wr(8'h04, 32'h8765_4321);
        wr(8'h00, 32'h8405);
        fr = '0;
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b1, o);
            fr = {fr[46:0], o};
        end
        wr(8'h00, 32'h8006);
        check(cmd_word == 16'h8405, "R10 command word kept", {112'b0, cmd_word}, 128'h8405);
        check(cmd_word[15], "R3 new flag while sending", {127'b0, cmd_word[15]}, 128'b1);
        for (int i = 5; i < 48; i++) begin
            step(1'b1, 1'b1, o);
            fr = {fr[46:0], o};
        end
        send_idle(1, 1'b1);
        check(fr == exp_frame(6'd5, 32'h8765_4321), "R10 frame unchanged", {80'b0, fr},
              {80'b0, exp_frame(6'd5, 32'h8765_4321)});
        check(!cmd_word[15], "R3 no-response ends after frame", {127'b0, cmd_word[15]}, 128'b0);

        // R8 busy wait released by DAT0
        wr(8'h20, 32'h7FF);
        send_frame(16'h880C, 32'h0, 32'd20, fr);
        send_idle(1, 1'b1);
        send_bits(short_resp(6'd12, 32'h0000_0900, 1'b0), 48);
        send_idle(5, 1'b0);
        check(cmd_word[15] && !stat[10], "R8 held during busy", {126'b0, cmd_word[15], stat[10]},
              128'h2);
        send_idle(1, 1'b1);
        check(!cmd_word[15] && stat[10] && !cmd_word[14], "R8 busy released",
              {125'b0, cmd_word[15], stat[10], cmd_word[14]}, 128'h2);

        // R8 busy wait that exceeds the timeout
        wr(8'h20, 32'h7FF);
        send_frame(16'h880C, 32'h0, 32'd3, fr);
        send_bits(short_resp(6'd12, 32'h0000_0900, 1'b0), 48);
        send_idle(3, 1'b0);
        check(cmd_word[15], "R8 busy within timeout", {127'b0, cmd_word[15]}, 128'b1);
        send_idle(1, 1'b0);
        check(!cmd_word[15] && cmd_word[14] && stat[6] && !stat[10], "R8 busy timeout",
              {124'b0, cmd_word[15], cmd_word[14], stat[6], stat[10]}, 128'h6);

        // R9 long plus busy rejected, R11 fail cleared by next write
        oe_seen = 0;
        wr(8'h00, 32'h8A03);
        send_idle(2, 1'b1);
        check(!cmd_word[15] && cmd_word[14] && oe_seen == 0, "R9 long busy rejected",
              {126'b0, cmd_word[15], cmd_word[14]}, 128'h1);
        wr(8'h00, 32'h0003);
        check(cmd_word == 16'h0003, "R11 fail cleared by write", {112'b0, cmd_word}, 128'h3);

        done = 1;
        report();
        $finish;
    end
endmodule